// File: doc/BRIEF.md
# Demand and Prefetch Request Arbiter

This block stands between a cache miss path, an address predictor and a single memory request port. Demand misses enter through a ready/valid input. Each accepted miss is queued for memory and, in the same cycle, queued a second time on an observation stream that trains the predictor. Predicted prefetch addresses arrive on a valid-only input and are queued separately. The single memory port is shared by the two queues, and a queued demand always takes the port ahead of any queued prefetch.

The block also removes redundant traffic by comparing line addresses across its queues. A prefetch for a line that a pending demand already covers is discarded, and that demand's observation entry is withdrawn so the predictor does not train on it. A demand for a line that already has a pending prefetch replaces that prefetch, and the demand is kept off the observation stream. A small ring holds the lines of the most recently issued prefetches, and any new prefetch that hits the ring is dropped. Entries are removed by marking them invalid. An invalid entry is retired from the head of its queue in one cycle and never reaches an output.

All comparisons use the line address, which is the address with its low offset bits ignored. Every address the block emits has those offset bits cleared.

Top module: `miss_pf_arbiter`

## Requirements
- R1: Every accepted demand is presented once on the memory port with `mem_is_pf`=0, and once on the observation port, each in order of acceptance, except where R3 or R4 removes the observation copy.
- R2: While any demand is queued, the memory port shows the oldest demand. A prefetch is shown only when the demand queue is empty.
- R3: A prefetch whose line equals a valid entry in the observation queue, or equals a demand accepted in the same cycle, is discarded. Every matching observation entry is removed, and the same-cycle demand is not written to the observation queue.
- R4: An accepted demand whose line equals a valid queued prefetch is written to the demand queue only. Every matching prefetch entry is removed.
- R5: A prefetch whose line equals one of the last FILT_N prefetch lines issued on the memory port is dropped. The ring overwrites its oldest entry on each issue.
- R6: A removed entry at the head of a queue is retired in one cycle without appearing on the memory or observation port.
- R7: `dmd_ready` is 0 whenever the demand queue or the observation queue holds its full depth of entries, counting removed entries not yet retired. Otherwise it is 1.
- R8: A prefetch arriving while the prefetch queue holds PQ_DEPTH entries is dropped without any other effect.
- R9: The line address is address bits [ADDR_W-1:OFF_W]. Both output addresses carry zeros in bits [OFF_W-1:0].
- R10: After reset, `mem_valid` and `obs_valid` are 0, `dmd_ready` is 1, and the recent-issue ring is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dmd_valid | input | 1 | Demand miss present |
| dmd_addr | input | ADDR_W | Demand miss address |
| dmd_ready | output | 1 | Demand can be accepted |
| pf_valid | input | 1 | Predicted prefetch present |
| pf_addr | input | ADDR_W | Predicted prefetch address |
| mem_valid | output | 1 | Memory request present |
| mem_addr | output | ADDR_W | Memory request line address |
| mem_is_pf | output | 1 | 1 for a prefetch request, 0 for a demand |
| mem_ready | input | 1 | Memory takes the request this cycle |
| obs_valid | output | 1 | Observation entry present |
| obs_addr | output | ADDR_W | Observed demand line address |
| obs_ready | input | 1 | Predictor takes the observation this cycle |

## Verification
The cross-queue rules are tried with directed patterns, and each pattern separates two outcomes. A prefetch that follows a stalled demand to the same line, at a different offset, tells a line compare apart from a full-address compare and shows whether the observation entry is withdrawn. A prefetch that arrives together with an equal demand shows whether the same-cycle case is handled. A demand that lands on a queued prefetch, whether at the queue head or in the middle, shows whether the demand replaces the prefetch. Repeated prefetches before and after FILT_N other issues tell the ring's reach apart from permanent suppression. Queues are filled while their consumers stall, which shows the ready and drop limits. A long mixed phase over a small pool of lines, with random back-pressure on both outputs, drives all of these rules at once against a cycle-level model.

// File: rtl/mpa_pkg.sv
// Shared types for the demand/prefetch arbiter.
package mpa_pkg;
    // Which source owns the memory port in the current cycle.
    typedef enum logic [1:0] {
        GNT_NONE     = 2'd0,
        GNT_DEMAND   = 2'd1,
        GNT_PREFETCH = 2'd2
    } grant_e;
endpackage

// File: rtl/line_queue.sv
// Circular FIFO of line addresses in which any entry can be invalidated.
// Holds up to DEPTH entries. An entry is first occupied and valid.
// Invalidation clears only the valid bit. An occupied but invalid head
// entry is retired on its own in one cycle, whether or not pop_req is set.
// cmp_hit reports whether any valid entry equals cmp_line. When kill is set,
// every such entry is invalidated. Pushes while full are ignored; the caller
// is expected to gate them.
module line_queue #(
    parameter int DEPTH  = 4,
    parameter int LINE_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [LINE_W-1:0] push_line,
    input  logic              pop_req,
    input  logic [LINE_W-1:0] cmp_line,
    input  logic              kill,
    output logic              cmp_hit,
    output logic              head_vld,
    output logic [LINE_W-1:0] head_line,
    output logic              full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [LINE_W-1:0] line_q [DEPTH];
    logic [DEPTH-1:0]  vld_q;
    logic [DEPTH-1:0]  occ_q;
    logic [PTR_W-1:0]  rd_q;
    logic [PTR_W-1:0]  wr_q;
    logic [DEPTH-1:0]  match;
    logic              do_pop;
    logic              do_push;

    function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Parallel compare of every valid entry against the probe line.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = vld_q[g] && (line_q[g] == cmp_line);
    end

    assign cmp_hit   = |match;
    assign head_vld  = vld_q[rd_q];
    assign head_line = line_q[rd_q];
    assign full      = occ_q[wr_q];
    assign do_push   = push && !full;
    assign do_pop    = occ_q[rd_q] && (!vld_q[rd_q] || pop_req);

    // Per-slot update: a write at the tail, a release at the head, or an invalidation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= '0;
            vld_q <= '0;
            for (int i = 0; i < DEPTH; i++) line_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (do_push && (wr_q == PTR_W'(i))) begin
                    occ_q[i]  <= 1'b1;
                    vld_q[i]  <= 1'b1;
                    line_q[i] <= push_line;
                end else if (do_pop && (rd_q == PTR_W'(i))) begin
                    occ_q[i] <= 1'b0;
                    vld_q[i] <= 1'b0;
                end else if (kill && match[i]) begin
                    vld_q[i] <= 1'b0;
                end
            end
        end
    end

    // Read and write pointer advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
            wr_q <= '0;
        end else begin
            if (do_pop)  rd_q <= adv(rd_q);
            if (do_push) wr_q <= adv(wr_q);
        end
    end
endmodule

// File: rtl/recent_filter.sv
// Ring of the last N prefetch lines issued to memory, with a parallel lookup.
// Each insert overwrites the oldest slot. A lookup sees only the contents
// registered before the current cycle.
module recent_filter #(
    parameter int N      = 4,
    parameter int LINE_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insert,
    input  logic [LINE_W-1:0] ins_line,
    input  logic [LINE_W-1:0] look_line,
    output logic              hit
);
    localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

    logic [LINE_W-1:0] ring_q [N];
    logic [N-1:0]      used_q;
    logic [PTR_W-1:0]  ptr_q;
    logic [N-1:0]      match;

    // Compare the probe line against every filled slot.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = used_q[g] && (ring_q[g] == look_line);
    end
    assign hit = |match;

    // Record the issued line in the oldest slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used_q <= '0;
            ptr_q  <= '0;
            for (int i = 0; i < N; i++) ring_q[i] <= '0;
        end else if (insert) begin
            for (int i = 0; i < N; i++) begin
                if (ptr_q == PTR_W'(i)) begin
                    ring_q[i] <= ins_line;
                    used_q[i] <= 1'b1;
                end
            end
            ptr_q <= (ptr_q == PTR_W'(N - 1)) ? '0 : ptr_q + 1'b1;
        end
    end
endmodule

// File: rtl/req_arbiter.sv
// Fixed-priority choice of the memory request: a demand head always beats
// a prefetch head. Purely combinational. Pop strobes are raised only on an
// accepted handshake.
module req_arbiter
    import mpa_pkg::*;
#(
    parameter int LINE_W = 26
) (
    input  logic              dq_vld,
    input  logic [LINE_W-1:0] dq_line,
    input  logic              pq_vld,
    input  logic [LINE_W-1:0] pq_line,
    input  logic              mem_ready,
    output grant_e            grant,
    output logic [LINE_W-1:0] out_line,
    output logic              dq_pop,
    output logic              pq_pop
);
    // Select the owner of the port and route its line.
    always_comb begin
        grant    = GNT_NONE;
        out_line = '0;
        if (dq_vld) begin
            grant    = GNT_DEMAND;
            out_line = dq_line;
        end else if (pq_vld) begin
            grant    = GNT_PREFETCH;
            out_line = pq_line;
        end
    end

    assign dq_pop = (grant == GNT_DEMAND)   && mem_ready;
    assign pq_pop = (grant == GNT_PREFETCH) && mem_ready;
endmodule

// File: rtl/miss_pf_arbiter.sv
// Demand/prefetch request arbiter in front of one memory port.
// An accepted demand goes to the demand queue and, unless it replaces a
// queued prefetch, to the observation queue. A predicted prefetch is
// discarded if it repeats a pending observation, a same-cycle demand,
// a recently issued prefetch, or meets a full prefetch queue.
// Assumes: every compare is on line address (offset bits ignored); all
// outputs depend on registered state only.
module miss_pf_arbiter
    import mpa_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int OFF_W    = 6,
    parameter int DQ_DEPTH = 4,
    parameter int OQ_DEPTH = 4,
    parameter int PQ_DEPTH = 4,
    parameter int FILT_N   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dmd_valid,
    input  logic [ADDR_W-1:0] dmd_addr,
    output logic              dmd_ready,
    input  logic              pf_valid,
    input  logic [ADDR_W-1:0] pf_addr,
    output logic              mem_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_is_pf,
    input  logic              mem_ready,
    output logic              obs_valid,
    output logic [ADDR_W-1:0] obs_addr,
    input  logic              obs_ready
);
    localparam int LINE_W = ADDR_W - OFF_W;

    logic [LINE_W-1:0] dline, pline;
    logic              unused_offsets;
    logic              dq_full, oq_full, pq_full;
    logic              dq_head_vld, oq_head_vld, pq_head_vld;
    logic [LINE_W-1:0] dq_head_line, oq_head_line, pq_head_line;
    logic              pq_hit, oq_hit, filt_hit, dq_cmp_unused;
    logic              dmd_acc, dmd_to_oq, same_cyc, oq_push;
    logic              pf_drop, pq_push;
    logic              dq_pop, pq_pop;
    logic [LINE_W-1:0] out_line;
    grant_e            grant;

    assign dline          = dmd_addr[ADDR_W-1:OFF_W];
    assign pline          = pf_addr[ADDR_W-1:OFF_W];
    assign unused_offsets = ^{dmd_addr[OFF_W-1:0], pf_addr[OFF_W-1:0]};

    // Demand intake: blocked if either queue it feeds is full.
    assign dmd_ready = !dq_full && !oq_full;
    assign dmd_acc   = dmd_valid && dmd_ready;
    assign dmd_to_oq = dmd_acc && !pq_hit;

    // A prefetch equal to a demand entering the observation queue this cycle
    // cancels that observation write, exactly like a stored match.
    assign same_cyc = pf_valid && dmd_to_oq && (pline == dline);
    assign oq_push  = dmd_to_oq && !same_cyc;
    assign pf_drop  = oq_hit || same_cyc || filt_hit || pq_full;
    assign pq_push  = pf_valid && !pf_drop;

    line_queue #(.DEPTH(DQ_DEPTH), .LINE_W(LINE_W)) u_dq (
        .clk(clk), .rst_n(rst_n),
        .push(dmd_acc), .push_line(dline),
        .pop_req(dq_pop),
        .cmp_line(dline), .kill(1'b0), .cmp_hit(dq_cmp_unused),
        .head_vld(dq_head_vld), .head_line(dq_head_line), .full(dq_full)
    );

    line_queue #(.DEPTH(OQ_DEPTH), .LINE_W(LINE_W)) u_oq (
        .clk(clk), .rst_n(rst_n),
        .push(oq_push), .push_line(dline),
        .pop_req(obs_ready),
        .cmp_line(pline), .kill(pf_valid), .cmp_hit(oq_hit),
        .head_vld(oq_head_vld), .head_line(oq_head_line), .full(oq_full)
    );

    line_queue #(.DEPTH(PQ_DEPTH), .LINE_W(LINE_W)) u_pq (
        .clk(clk), .rst_n(rst_n),
        .push(pq_push), .push_line(pline),
        .pop_req(pq_pop),
        .cmp_line(dline), .kill(dmd_acc), .cmp_hit(pq_hit),
        .head_vld(pq_head_vld), .head_line(pq_head_line), .full(pq_full)
    );

    recent_filter #(.N(FILT_N), .LINE_W(LINE_W)) u_filt (
        .clk(clk), .rst_n(rst_n),
        .insert(pq_pop), .ins_line(pq_head_line),
        .look_line(pline), .hit(filt_hit)
    );

    req_arbiter #(.LINE_W(LINE_W)) u_arb (
        .dq_vld(dq_head_vld), .dq_line(dq_head_line),
        .pq_vld(pq_head_vld), .pq_line(pq_head_line),
        .mem_ready(mem_ready),
        .grant(grant), .out_line(out_line),
        .dq_pop(dq_pop), .pq_pop(pq_pop)
    );

    assign mem_valid = (grant != GNT_NONE);
    assign mem_is_pf = (grant == GNT_PREFETCH);
    assign mem_addr  = {out_line, {OFF_W{1'b0}}};
    assign obs_valid = oq_head_vld;
    assign obs_addr  = {oq_head_line, {OFF_W{1'b0}}};
endmodule

// File: rtl/miss_pf_arbiter_chk.sv
// Property checker for miss_pf_arbiter, attached by bind below.
module miss_pf_arbiter_chk #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dmd_ready,
    input logic              mem_valid,
    input logic              mem_is_pf,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              obs_valid,
    input logic [ADDR_W-1:0] obs_addr,
    input logic              dq_head_vld,
    input logic              pq_head_vld,
    input logic              dq_full,
    input logic              oq_full
);
    a_r2_demand_first: assert property (@(posedge clk) disable iff (!rst_n)
        dq_head_vld |-> (mem_valid && !mem_is_pf));

    a_r7_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_full || oq_full) |-> !dmd_ready);

    a_r9_mem_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_addr[OFF_W-1:0] == '0));

    a_r9_obs_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        obs_valid |-> (obs_addr[OFF_W-1:0] == '0));

    a_r6_no_removed_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_is_pf) |-> pq_head_vld);
endmodule

bind miss_pf_arbiter miss_pf_arbiter_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .dmd_ready(dmd_ready),
    .mem_valid(mem_valid), .mem_is_pf(mem_is_pf), .mem_addr(mem_addr),
    .obs_valid(obs_valid), .obs_addr(obs_addr),
    .dq_head_vld(dq_head_vld), .pq_head_vld(pq_head_vld),
    .dq_full(dq_full), .oq_full(oq_full)
);

// File: tb/miss_pf_arbiter_tb.sv
`timescale 1ns/1ps
// Bench: a behavioural queue model, compared against the DUT every cycle.
module miss_pf_arbiter_tb;
    localparam int OFF   = 6;
    localparam int DQD   = 4;
    localparam int OQD   = 4;
    localparam int PQD   = 4;
    localparam int FN    = 4;
    localparam int LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dmd_valid = 1'b0, pf_valid = 1'b0, mem_ready = 1'b0, obs_ready = 1'b0;
    logic [31:0] dmd_addr = '0, pf_addr = '0;
    logic        dmd_ready, mem_valid, mem_is_pf, obs_valid;
    logic [31:0] mem_addr, obs_addr;

    int    errors = 0;
    int    checks = 0;
    int    cycles = 0;
    string cur_req = "R10";

    always #2.5 clk = ~clk;

    miss_pf_arbiter u_dut (
        .clk(clk), .rst_n(rst_n),
        .dmd_valid(dmd_valid), .dmd_addr(dmd_addr), .dmd_ready(dmd_ready),
        .pf_valid(pf_valid), .pf_addr(pf_addr),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_is_pf(mem_is_pf), .mem_ready(mem_ready),
        .obs_valid(obs_valid), .obs_addr(obs_addr), .obs_ready(obs_ready)
    );

    // Reference state: plain queues of line numbers with a live flag.
    typedef struct { int unsigned line; bit v; } ent_t;
    int unsigned m_dq[$];
    ent_t        m_oq[$];
    ent_t        m_pq[$];
    int unsigned f_line[FN];
    bit          f_v[FN];
    int          f_ptr = 0;

    // Expected outputs from the model state alone.
    task automatic expect_out(output bit mv, output bit mpf, output int unsigned ma,
                              output bit ov, output int unsigned oa, output bit rdy);
        mv = 0; mpf = 0; ma = 0; ov = 0; oa = 0;
        if (m_dq.size() > 0) begin
            mv = 1; ma = m_dq[0] << OFF;
        end else if (m_pq.size() > 0 && m_pq[0].v) begin
            mv = 1; mpf = 1; ma = m_pq[0].line << OFF;
        end
        if (m_oq.size() > 0 && m_oq[0].v) begin
            ov = 1; oa = m_oq[0].line << OFF;
        end
        rdy = (m_dq.size() < DQD) && (m_oq.size() < OQD);
    endtask

    task automatic compare_now();
        bit mv, mpf, ov, rdy;
        int unsigned ma, oa;
        expect_out(mv, mpf, ma, ov, oa, rdy);
        checks++;
        if (mem_valid !== mv || (mv && (mem_is_pf !== mpf || mem_addr !== ma)) ||
            obs_valid !== ov || (ov && obs_addr !== oa) || dmd_ready !== rdy) begin
            errors++;
            $display("FAIL %s t=%0t got mem=%b/%b/%h obs=%b/%h rdy=%b exp mem=%b/%b/%h obs=%b/%h rdy=%b",
                     cur_req, $time, mem_valid, mem_is_pf, mem_addr, obs_valid, obs_addr, dmd_ready,
                     mv, mpf, ma, ov, oa, rdy);
        end
    endtask

    // One clock of the reference behaviour.
    task automatic model_step(bit dv, int unsigned da, bit pv, int unsigned pa, bit mr, bit orr);
        bit mv, mpf, ov, rdy, acc, pq_hit, oq_hit, filt, same, to_oq, drop, pq_h0, oq_h0;
        int unsigned ma, oa, dl, pl;
        expect_out(mv, mpf, ma, ov, oa, rdy);
        acc = dv && rdy;
        dl = da >> OFF;
        pl = pa >> OFF;
        pq_hit = 0; oq_hit = 0; filt = 0;
        foreach (m_pq[i]) if (m_pq[i].v && m_pq[i].line == dl) pq_hit = 1;
        foreach (m_oq[i]) if (m_oq[i].v && m_oq[i].line == pl) oq_hit = 1;
        for (int i = 0; i < FN; i++) if (f_v[i] && f_line[i] == pl) filt = 1;
        to_oq = acc && !pq_hit;
        same  = pv && to_oq && (pl == dl);
        drop  = oq_hit || same || filt || (m_pq.size() >= PQD);
        pq_h0 = (m_pq.size() > 0) && m_pq[0].v;
        oq_h0 = (m_oq.size() > 0) && m_oq[0].v;
        if (acc) foreach (m_pq[i]) if (m_pq[i].line == dl) m_pq[i].v = 0;
        if (pv)  foreach (m_oq[i]) if (m_oq[i].line == pl) m_oq[i].v = 0;
        if (mv && !mpf && mr) void'(m_dq.pop_front());
        if (m_pq.size() > 0) begin
            if (!pq_h0) void'(m_pq.pop_front());
            else if (mv && mpf && mr) begin
                f_line[f_ptr] = m_pq[0].line;
                f_v[f_ptr] = 1;
                f_ptr = (f_ptr + 1) % FN;
                void'(m_pq.pop_front());
            end
        end
        if (m_oq.size() > 0) begin
            if (!oq_h0) void'(m_oq.pop_front());
            else if (orr) void'(m_oq.pop_front());
        end
        if (acc) m_dq.push_back(dl);
        if (to_oq && !same) m_oq.push_back('{line: dl, v: 1'b1});
        if (pv && !drop) m_pq.push_back('{line: pl, v: 1'b1});
    endtask

    // Drive one cycle of stimulus (called just after a falling edge).
    task automatic cyc(bit dv, int unsigned da, bit pv, int unsigned pa, bit mr, bit orr);
        dmd_valid = dv; dmd_addr = da; pf_valid = pv; pf_addr = pa;
        mem_ready = mr; obs_ready = orr;
        #1;
        compare_now();
        model_step(dv, da, pv, pa, mr, orr);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(int n, bit mr, bit orr);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, mr, orr);
    endtask

    function automatic int unsigned ln(int unsigned line, int unsigned off);
        return (line << OFF) | off;
    endfunction

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > LIMIT) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < FN; i++) begin f_v[i] = 0; f_line[i] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state (nothing out, ready high).
        cur_req = "R10";
        idle(2, 1, 1);

        // R1 and R9: demands with assorted offsets flow to both outputs.
        cur_req = "R1";
        cyc(1, ln(32'h40, 5), 0, 0, 1, 1);
        cyc(1, ln(32'h81, 63), 0, 0, 1, 1);
        cur_req = "R9";
        cyc(1, ln(32'hC0, 0), 0, 0, 1, 1);
        idle(4, 1, 1);

        // R2: queued prefetches wait behind later demands.
        cur_req = "R2";
        cyc(0, 0, 1, ln(32'h10, 1), 0, 1);
        cyc(0, 0, 1, ln(32'h11, 2), 0, 1);
        cyc(0, 0, 1, ln(32'h12, 3), 0, 1);
        cyc(1, ln(32'h20, 4), 0, 0, 0, 1);
        cyc(1, ln(32'h21, 4), 0, 0, 0, 1);
        idle(8, 1, 1);

        // R3: a prefetch repeats a stalled demand at another offset; also the same-cycle case.
        cur_req = "R3";
        cyc(1, ln(32'h30, 0), 0, 0, 0, 0);
        cyc(0, 0, 1, ln(32'h30, 7), 0, 0);
        idle(6, 1, 1);
        cyc(1, ln(32'h31, 0), 1, ln(32'h31, 3), 1, 1);
        idle(4, 1, 1);

        // R4: a demand replaces a queued prefetch, at the head and in the middle.
        cur_req = "R4";
        cyc(0, 0, 1, ln(32'h40, 0), 0, 1);
        cyc(1, ln(32'h40, 9), 0, 0, 0, 1);
        idle(4, 1, 1);
        cyc(0, 0, 1, ln(32'h70, 0), 0, 1);
        cyc(0, 0, 1, ln(32'h71, 0), 0, 1);
        cyc(0, 0, 1, ln(32'h72, 0), 0, 1);
        cyc(1, ln(32'h71, 1), 0, 0, 0, 1);
        idle(8, 1, 1);

        // R5: the recent-issue ring blocks repeats until FN other issues push the line out.
        cur_req = "R5";
        cyc(0, 0, 1, ln(32'h50, 0), 1, 1);
        idle(3, 1, 1);
        cyc(0, 0, 1, ln(32'h50, 8), 1, 1);
        idle(3, 1, 1);
        for (int k = 1; k <= FN; k++) begin
            cyc(0, 0, 1, ln(32'h50 + k, 0), 1, 1);
            idle(2, 1, 1);
        end
        cyc(0, 0, 1, ln(32'h50, 0), 1, 1);
        idle(4, 1, 1);

        // R6: removed entries at the heads are skipped without output.
        cur_req = "R6";
        cyc(1, ln(32'h60, 0), 0, 0, 0, 0);
        cyc(1, ln(32'h61, 0), 0, 0, 0, 0);
        cyc(0, 0, 1, ln(32'h60, 1), 0, 0);
        cyc(0, 0, 1, ln(32'h61, 1), 0, 0);
        idle(6, 1, 1);

        // R7: demand intake stalls when the stalled queues fill.
        cur_req = "R7";
        for (int k = 0; k < 6; k++) cyc(1, ln(32'h80 + k, 0), 0, 0, 0, 0);
        idle(3, 0, 1);
        idle(8, 1, 1);

        // R8: a full prefetch queue drops the overflow.
        cur_req = "R8";
        for (int k = 0; k < 6; k++) cyc(0, 0, 1, ln(32'h90 + k, 0), 0, 1);
        idle(10, 1, 1);

        // Mixed traffic over a small line pool with random back-pressure.
        cur_req = "R1";
        for (int k = 0; k < 3000; k++) begin
            cyc($urandom_range(0, 1), ln($urandom_range(0, 7), $urandom_range(0, 63)),
                $urandom_range(0, 1), ln($urandom_range(0, 7), $urandom_range(0, 63)),
                ($urandom_range(0, 3) != 0), ($urandom_range(0, 3) != 0));
        end
        idle(20, 1, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule